// File: doc/BRIEF.md
# SD Card Command Response Capture

This block is the command path of a memory-card host controller. Software loads a 32-bit argument and an 11-bit command word. If the stored word has its enable bit set, the block presents the command index and the argument to a card-side model or engine with a one-cycle issue strobe. The card side later answers with a done pulse that carries a reply length in bytes. When a reply is expected and its length is legal, the reply bytes follow one per cycle on a valid strobe. The block packs them into four 32-bit response words, most significant byte first, and raises a sticky completion flag.

The command word fields are: index in bits [5:0], reply-expected in bit 6, long-reply in bit 7, interrupt-mode in bit 8, hold-until-later (pending) in bit 9, and enable in bit 10. Commands that have interrupt mode or pending set are stored but never issued. The status flags are bit 2 (timeout), bit 6 (reply captured) and bit 7 (sent with no reply). Software clears them by writing a mask of ones. Serial line signalling and CRC handling belong to other blocks.

Top module: `sd_cmd_capture`

## Requirements
- R1: After reset, cardIssue and busy are low, and cmdWord, cmdArg, statFlags and respFlat are all zero.
- R2: A command write while idle with bit 10 set and bits 8 and 9 clear makes cardIssue high for exactly one cycle, in the cycle after the write, with cardIndex equal to the written bits [5:0] and cardArg equal to the stored argument.
- R3: A command write with bit 8 or bit 9 set is stored with bit 10 cleared, produces no cardIssue, leaves busy low and changes no status flag.
- R4: While an issued command is in flight, busy is high and cmdWord bit 10 reads 1. When the command completes, busy falls and bit 10 reads 0 with the other bits unchanged.
- R5: With bit 6 clear, the done pulse sets status bit 7 and ends the command; any reply bytes are ignored and the response words keep their values.
- R6: With bit 6 set, a reply length of 0, a length of 4 while bit 7 is set, or any length other than 4 or 16 sets status bit 2, ends the command, and leaves the response words unchanged.
- R7: For a legal reply, byte k (counted from 0) is written to respFlat bits [32*(k/4) + 31 - 8*(k%4) -: 8], so word 0 sits in respFlat[31:0]. Status bit 6 is set on the edge that takes the last byte. Bytes that arrive in the done cycle or after completion are ignored.
- R8: A legal 4-byte reply clears response words 1 to 3. In a 16-byte reply, bit 0 of word 3 is forced to 0.
- R9: Status flags stay set until a 1 in the matching bit of statClr clears them. Other flags are unaffected by the clear, and status bits other than 2, 6 and 7 always read 0.
- R10: Writes to the command or the argument while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Command word write strobe |
| cmdWrData | input | 11 | Command word to store |
| argWrEn | input | 1 | Argument write strobe |
| argWrData | input | ARG_W | Argument to store |
| statClr | input | 8 | Status clear mask; ones clear flags |
| cmdWord | output | 11 | Stored command word |
| cmdArg | output | ARG_W | Stored argument |
| statFlags | output | 8 | Sticky status flags |
| respFlat | output | NUM_WORDS*WORD_W | Response words, word 0 in the low bits |
| busy | output | 1 | A command is in flight |
| cardIssue | output | 1 | One-cycle command issue strobe |
| cardIndex | output | 6 | Command index to the card side |
| cardArg | output | ARG_W | Argument to the card side |
| cardDone | input | 1 | Card side has finished; cardLen valid |
| cardLen | input | LEN_W | Reply length in bytes |
| cardByteValid | input | 1 | Reply byte valid |
| cardByte | input | 8 | Reply byte |

## Verification
A wrong byte counter or lane decode places a byte in the wrong field of respFlat. This shows on the cycle after the last byte, when the packed words are compared with the arithmetic byte pattern. A wrong state transition shows in one of two ways. It can leave busy high or bit 10 set after the expected completion edge. It can also produce a missing or repeated cardIssue pulse, which is visible one cycle after the command write. A fault in the length decode raises the wrong status flag in the cycle after the done pulse, and the sweep over every mix of the reply-expected bit, the long-reply bit and the reply length brings it out.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int CMD_W    = 11;
  localparam int IDX_W    = 6;
  localparam int BIT_RESP = 6;
  localparam int BIT_LONG = 7;
  localparam int BIT_INT  = 8;
  localparam int BIT_PEND = 9;
  localparam int BIT_EN   = 10;
  localparam int STAT_W   = 8;
  localparam int ST_TOUT  = 2;
  localparam int ST_RESP  = 6;
  localparam int ST_SENT  = 7;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RECV} cmdState_t;

  typedef struct packed {
    logic loadCmd;
    logic loadArg;
    logic dropEnable;
    logic clearUpper;
    logic startRecv;
    logic takeByte;
    logic setSent;
    logic setResp;
    logic setTimeout;
  } ctrlStrobes_t;
endpackage

// File: rtl/sd_cmd_ctrl.sv
module sd_cmd_ctrl
  import sd_cmd_pkg::*;
#(
  parameter int LEN_W = 5,
  parameter int CNT_W = 4,
  parameter int SHORT_LEN = 4,
  parameter int LONG_LEN = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrEn,
  input  logic             wrEnable,
  input  logic             wrInt,
  input  logic             wrPend,
  input  logic             argWrEn,
  input  logic             wantResp,
  input  logic             wantLong,
  input  logic             cardDone,
  input  logic [LEN_W-1:0] cardLen,
  input  logic             cardByteValid,
  input  logic [CNT_W-1:0] byteCount,
  output ctrlStrobes_t     strb,
  output logic             cardIssue,
  output logic             busy
);
  cmdState_t state, stateNext;
  logic [LEN_W-1:0] lenReg;
  logic lenBad, lastByte;

  assign lenBad = (cardLen == '0) ||
                  (cardLen == LEN_W'(SHORT_LEN) && wantLong) ||
                  (cardLen != LEN_W'(SHORT_LEN) && cardLen != LEN_W'(LONG_LEN));
  assign lastByte = (LEN_W'(byteCount) == lenReg - LEN_W'(1));

  always_comb begin
    strb = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        strb.loadCmd = cmdWrEn;
        strb.loadArg = argWrEn;
        if (cmdWrEn && wrEnable) begin
          if (wrInt || wrPend) strb.dropEnable = 1'b1;
          else stateNext = S_ISSUE;
        end
      end
      S_ISSUE: stateNext = S_WAIT;
      S_WAIT: begin
        if (cardDone) begin
          if (!wantResp) begin
            strb.setSent = 1'b1;
            strb.dropEnable = 1'b1;
            stateNext = S_IDLE;
          end else if (lenBad) begin
            strb.setTimeout = 1'b1;
            strb.dropEnable = 1'b1;
            stateNext = S_IDLE;
          end else begin
            strb.startRecv = 1'b1;
            strb.clearUpper = (cardLen == LEN_W'(SHORT_LEN));
            stateNext = S_RECV;
          end
        end
      end
      S_RECV: begin
        if (cardByteValid) begin
          strb.takeByte = 1'b1;
          if (lastByte) begin
            strb.setResp = 1'b1;
            strb.dropEnable = 1'b1;
            stateNext = S_IDLE;
          end
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      lenReg <= '0;
    end else begin
      state <= stateNext;
      if (strb.startRecv) lenReg <= cardLen;
    end
  end

  assign cardIssue = (state == S_ISSUE);
  assign busy = (state != S_IDLE);
endmodule

// File: rtl/sd_cmd_dp.sv
module sd_cmd_dp
  import sd_cmd_pkg::*;
#(
  parameter int ARG_W = 32,
  parameter int WORD_W = 32,
  parameter int NUM_WORDS = 4,
  parameter int CNT_W = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobes_t                strb,
  input  logic [CMD_W-1:0]            cmdWrData,
  input  logic [ARG_W-1:0]            argWrData,
  input  logic [STAT_W-1:0]           statClr,
  input  logic [7:0]                  cardByte,
  output logic [CMD_W-1:0]            cmdWord,
  output logic [ARG_W-1:0]            cmdArg,
  output logic [STAT_W-1:0]           statFlags,
  output logic [NUM_WORDS*WORD_W-1:0] respFlat,
  output logic [CNT_W-1:0]            byteCount
);
  localparam int LANES = WORD_W / 8;
  localparam int BYTES = NUM_WORDS * LANES;
  localparam logic [CMD_W-1:0] EN_MASK = CMD_W'(1) << BIT_EN;

  logic [NUM_WORDS-1:0][WORD_W-1:0] respMem;
  logic [STAT_W-1:0] statSet;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdWord <= '0;
      cmdArg <= '0;
    end else begin
      if (strb.loadCmd)
        cmdWord <= strb.dropEnable ? (cmdWrData & ~EN_MASK) : cmdWrData;
      else if (strb.dropEnable)
        cmdWord <= cmdWord & ~EN_MASK;
      if (strb.loadArg) cmdArg <= argWrData;
    end
  end

  always_comb begin
    statSet = '0;
    statSet[ST_TOUT] = strb.setTimeout;
    statSet[ST_RESP] = strb.setResp;
    statSet[ST_SENT] = strb.setSent;
  end

  always_ff @(posedge clk) begin
    if (!rstN) statFlags <= '0;
    else statFlags <= (statFlags & ~statClr) | statSet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) byteCount <= '0;
    else if (strb.startRecv) byteCount <= '0;
    else if (strb.takeByte) byteCount <= byteCount + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respMem <= '0;
    end else begin
      for (int w = 1; w < NUM_WORDS; w++)
        if (strb.clearUpper) respMem[w] <= '0;
      for (int w = 0; w < NUM_WORDS; w++)
        for (int l = 0; l < LANES; l++)
          if (strb.takeByte && byteCount == CNT_W'(w * LANES + l))
            respMem[w][WORD_W-1-8*l -: 8] <=
              (w * LANES + l == BYTES - 1) ? {cardByte[7:1], 1'b0} : cardByte;
    end
  end

  assign respFlat = respMem;
endmodule

// File: rtl/sd_cmd_capture.sv
module sd_cmd_capture
  import sd_cmd_pkg::*;
#(
  parameter int ARG_W = 32,
  parameter int WORD_W = 32,
  parameter int NUM_WORDS = 4,
  parameter int LEN_W = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cmdWrEn,
  input  logic [10:0]                 cmdWrData,
  input  logic                        argWrEn,
  input  logic [ARG_W-1:0]            argWrData,
  input  logic [7:0]                  statClr,
  output logic [10:0]                 cmdWord,
  output logic [ARG_W-1:0]            cmdArg,
  output logic [7:0]                  statFlags,
  output logic [NUM_WORDS*WORD_W-1:0] respFlat,
  output logic                        busy,
  output logic                        cardIssue,
  output logic [5:0]                  cardIndex,
  output logic [ARG_W-1:0]            cardArg,
  input  logic                        cardDone,
  input  logic [LEN_W-1:0]            cardLen,
  input  logic                        cardByteValid,
  input  logic [7:0]                  cardByte
);
  localparam int BYTES = NUM_WORDS * WORD_W / 8;
  localparam int CNT_W = $clog2(BYTES);

  ctrlStrobes_t strb;
  logic [CNT_W-1:0] byteCount;

  sd_cmd_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W), .SHORT_LEN(WORD_W / 8), .LONG_LEN(BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn),
    .wrEnable(cmdWrData[BIT_EN]), .wrInt(cmdWrData[BIT_INT]), .wrPend(cmdWrData[BIT_PEND]),
    .argWrEn(argWrEn), .wantResp(cmdWord[BIT_RESP]), .wantLong(cmdWord[BIT_LONG]),
    .cardDone(cardDone), .cardLen(cardLen), .cardByteValid(cardByteValid),
    .byteCount(byteCount), .strb(strb), .cardIssue(cardIssue), .busy(busy)
  );

  sd_cmd_dp #(.ARG_W(ARG_W), .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdWrData(cmdWrData), .argWrData(argWrData),
    .statClr(statClr), .cardByte(cardByte), .cmdWord(cmdWord), .cmdArg(cmdArg),
    .statFlags(statFlags), .respFlat(respFlat), .byteCount(byteCount)
  );

  assign cardIndex = cmdWord[IDX_W-1:0];
  assign cardArg = cmdArg;
endmodule

// File: rtl/sd_cmd_capture_chk.sv
module sd_cmd_capture_chk
  import sd_cmd_pkg::*;
#(
  parameter int ARG_W = 32,
  parameter int WORD_W = 32,
  parameter int NUM_WORDS = 4
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        cardIssue,
  input logic                        busy,
  input logic [10:0]                 cmdWord,
  input logic [ARG_W-1:0]            cmdArg,
  input logic [7:0]                  statFlags,
  input logic [7:0]                  statClr,
  input logic [NUM_WORDS*WORD_W-1:0] respFlat
);
  AST_ISSUE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cardIssue |=> !cardIssue); // R2
  AST_ISSUE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    cardIssue |-> (cmdWord[BIT_EN] && !cmdWord[BIT_INT] && !cmdWord[BIT_PEND])); // R3
  AST_ENABLE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !cmdWord[BIT_EN]); // R4
  AST_ENABLE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> cmdWord[BIT_EN]); // R4
  AST_WORD3_LSB: assert property (@(posedge clk) disable iff (!rstN)
    respFlat[(NUM_WORDS-1)*WORD_W] == 1'b0); // R8
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (|(statFlags & ~statClr)) |=>
      ((statFlags & $past(statFlags & ~statClr)) == $past(statFlags & ~statClr))); // R9
  AST_UNUSED_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (statFlags & 8'b0011_1011) == 8'h00); // R9
  AST_ARG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(cmdArg)); // R10
endmodule

bind sd_cmd_capture sd_cmd_capture_chk #(.ARG_W(ARG_W), .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) uChk (
  .clk(clk), .rstN(rstN), .cardIssue(cardIssue), .busy(busy), .cmdWord(cmdWord),
  .cmdArg(cmdArg), .statFlags(statFlags), .statClr(statClr), .respFlat(respFlat)
);

// File: tb/sd_cmd_capture_test.sv
`timescale 1ns/1ps
module sd_cmd_capture_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWrEn = 1'b0;
  logic [10:0] cmdWrData = '0;
  logic argWrEn = 1'b0;
  logic [31:0] argWrData = '0;
  logic [7:0] statClr = '0;
  logic [10:0] cmdWord;
  logic [31:0] cmdArg;
  logic [7:0] statFlags;
  logic [127:0] respFlat;
  logic busy, cardIssue;
  logic [5:0] cardIndex;
  logic [31:0] cardArg;
  logic cardDone = 1'b0;
  logic [4:0] cardLen = '0;
  logic cardByteValid = 1'b0;
  logic [7:0] cardByte = '0;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  logic [127:0] expResp = '0;
  logic [7:0] expStat = '0;
  logic [31:0] expArg = '0;

  always #5 clk = ~clk;

  sd_cmd_capture uut (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData), .argWrEn(argWrEn),
    .argWrData(argWrData), .statClr(statClr), .cmdWord(cmdWord), .cmdArg(cmdArg),
    .statFlags(statFlags), .respFlat(respFlat), .busy(busy), .cardIssue(cardIssue),
    .cardIndex(cardIndex), .cardArg(cardArg), .cardDone(cardDone), .cardLen(cardLen),
    .cardByteValid(cardByteValid), .cardByte(cardByte)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      testsFailed = testsFailed + 1;
      $display("FAIL R1 watchdog expired: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", testsRun + 1, testsFailed);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    testsRun = testsRun + 1;
    if (act !== exp) begin
      testsFailed = testsFailed + 1;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic runCmd(input logic [10:0] cmd, input logic [31:0] arg, input int len, input int seed);
    bit issue;
    bit bad;
    logic [7:0] b;
    issue = cmd[10] && !cmd[9] && !cmd[8];
    @(negedge clk); argWrEn = 1'b1; argWrData = arg;
    @(negedge clk); argWrEn = 1'b0; cmdWrEn = 1'b1; cmdWrData = cmd;
    expArg = arg;
    @(negedge clk); cmdWrEn = 1'b0;
    check(issue ? "R2 issue strobe" : "R3 no issue", 128'(cardIssue), 128'(issue));
    if (issue) begin
      check("R2 index", 128'(cardIndex), 128'(cmd[5:0]));
      check("R2 argument", 128'(cardArg), 128'(arg));
      check("R4 enable while busy", 128'({busy, cmdWord[10]}), 128'(2'b11));
      argWrEn = 1'b1; argWrData = ~arg; cmdWrEn = 1'b1; cmdWrData = 11'h7ff;
      @(negedge clk); argWrEn = 1'b0; cmdWrEn = 1'b0;
      check("R2 single pulse", 128'(cardIssue), 128'(0));
      cardDone = 1'b1; cardLen = 5'(len); cardByteValid = 1'b1; cardByte = 8'h5a;
      @(negedge clk); cardDone = 1'b0; cardByteValid = 1'b0;
      bad = (len == 0) || (len == 4 && cmd[7]) || (len != 4 && len != 16);
      if (!cmd[6]) begin
        expStat = expStat | 8'h80;
      end else if (bad) begin
        expStat = expStat | 8'h04;
      end else begin
        if (len == 4) expResp[127:32] = '0;
        for (int k = 0; k < len; k++) begin
          b = pat(seed, k);
          cardByteValid = 1'b1; cardByte = b;
          if (k == 15) b[0] = 1'b0;
          expResp[32 * (k / 4) + 31 - 8 * (k % 4) -: 8] = b;
          @(negedge clk);
        end
        expStat = expStat | 8'h40;
      end
      cardByteValid = 1'b1; cardByte = 8'hc3;
      @(negedge clk); cardByteValid = 1'b0;
    end
    check("R4 idle after command", 128'(busy), 128'(0));
    check(issue ? "R4 enable cleared" : "R3 stored without enable", 128'(cmdWord), 128'(cmd & 11'h3ff));
    check("R10 argument kept", 128'(cmdArg), 128'(expArg));
    check(!cmd[6] ? "R5 status" : "R6 R7 status", 128'(statFlags), 128'(expStat));
    check(!cmd[6] ? "R5 response kept" : "R7 R8 response", respFlat, expResp);
  endtask

  task automatic clearStat(input logic [7:0] mask);
    @(negedge clk); statClr = mask;
    @(negedge clk); statClr = '0;
    expStat = expStat & ~mask;
    check("R9 status after clear", 128'(statFlags), 128'(expStat));
  endtask

  initial begin
    int lens[10] = '{0, 1, 3, 4, 5, 15, 16, 17, 20, 31};
    int seed;
    seed = 0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {cmdWord, cmdArg, statFlags, busy, cardIssue}, '0);
    check("R1 reset response", respFlat, '0);
    rstN = 1'b1;
    for (int resp = 0; resp < 2; resp++)
      for (int lng = 0; lng < 2; lng++)
        for (int li = 0; li < 10; li++) begin
          seed = seed + 1;
          runCmd({1'b1, 1'b0, 1'b0, 1'(lng), 1'(resp), 6'(seed * 7)},
                 32'(seed) * 32'h9e37_79b1, lens[li], seed);
          clearStat(8'hff);
        end
    runCmd({1'b1, 1'b1, 1'b0, 2'b01, 6'd17}, 32'h1234_5678, 16, 1);
    runCmd({1'b1, 1'b0, 1'b1, 2'b01, 6'd18}, 32'h8765_4321, 16, 2);
    runCmd({1'b0, 1'b0, 1'b0, 2'b01, 6'd19}, 32'h0bad_f00d, 16, 3);
    runCmd({1'b1, 1'b0, 1'b0, 2'b00, 6'd2}, 32'h0000_0001, 0, 4);
    runCmd({1'b1, 1'b0, 1'b0, 2'b11, 6'd9}, 32'h0000_0002, 4, 5);
    check("R9 two flags held", 128'(statFlags), 128'(8'h84));
    clearStat(8'h04);
    clearStat(8'h80);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule